// File: doc/BRIEF.md
# Three-Share Masked AND Gadget

This block computes the bitwise AND of two secret words while neither word ever appears in the clear inside the logic. Each operand enters as three Boolean shares, and the secret is the XOR of its three shares. The block returns three output shares whose XOR is the AND of the two secrets. Each output share is built from exactly two of the three share indices. The result is then captured in a register, so glitches in the combinational terms cannot reach downstream shared logic.

An upstream stage presents a fresh sharing with `in_valid` high. One clock later `out_valid` rises and the registered output shares are stable. Two fresh random words can be XORed into the outputs to refresh them. The three added masks cancel, so the unmasked result does not change. Refresh can be removed at elaboration. The gadget works lane by lane across a `W`-bit word, and it is meant to be chained with other degree-two shared stages.

Top module: `ti_and3`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `z1`, `z2` and `z3` are all zero.
- R2: `out_valid` in a cycle equals `in_valid` in the previous cycle.
- R3: One cycle after `in_valid` is high, `z1^z2^z3` equals `(a1^a2^a3) & (b1^b2^b3)` in every bit lane.
- R4: `z1` depends only on share index 1 and 2 inputs: it equals `a1&b1 ^ a1&b2 ^ a2&b1`, XOR `r1` when refresh is on. Changing `a3` or `b3` alone leaves it unchanged.
- R5: `z2` depends only on share index 1 and 3 inputs: it equals `a3&b3 ^ a3&b1 ^ a1&b3`, XOR `r2` when refresh is on. Changing `a2` or `b2` alone leaves it unchanged.
- R6: `z3` depends only on share index 2 and 3 inputs: it equals `a2&b2 ^ a2&b3 ^ a3&b2`, XOR `r1^r2` when refresh is on. Changing `a1` or `b1` alone leaves it unchanged.
- R7: With `REFRESH_EN` = 1 (default), the added masks are `r1`, `r2` and `r1^r2` on `z1`, `z2` and `z3`. Their XOR is zero, so R3 holds for any `r1` and `r2`.
- R8: When `in_valid` is low, `z1`, `z2` and `z3` keep their values on the next clock, whatever the share and random inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Input shares and randomness are valid; loads the output register |
| a1 | input | W | Operand A, share 1 |
| a2 | input | W | Operand A, share 2 |
| a3 | input | W | Operand A, share 3 |
| b1 | input | W | Operand B, share 1 |
| b2 | input | W | Operand B, share 2 |
| b3 | input | W | Operand B, share 3 |
| r1 | input | W | Fresh random word 1 for refresh |
| r2 | input | W | Fresh random word 2 for refresh |
| out_valid | output | 1 | Output shares are valid |
| z1 | output | W | Result, share 1 |
| z2 | output | W | Result, share 2 |
| z3 | output | W | Result, share 3 |

## Verification
Two kinds of fault can appear at the ports. A wrong cross term or a wrong share index changes the exact value of a single output share, and it shows on the first `out_valid` after a sharing that exercises that term. A mask that does not cancel breaks the unmasked XOR, and that also shows one cycle after the operation. A share that reads an index it must exclude is found by holding two share indices fixed and flipping the third: the protected output must not move on the next cycle. A clock-enable fault shows as output shares that change during an idle cycle.

// File: rtl/ti_and_pkg.sv
package ti_and_pkg;

  localparam int NSHARE = 3;

  // Output share i is built from share index own_idx(i) and nbr_idx(i);
  // the third index is excluded (non-completeness).
  function automatic int own_idx(input int i);
    case (i)
      0:       own_idx = 0;
      1:       own_idx = 2;
      default: own_idx = 1;
    endcase
  endfunction

  function automatic int nbr_idx(input int i);
    case (i)
      0:       nbr_idx = 1;
      1:       nbr_idx = 0;
      default: nbr_idx = 2;
    endcase
  endfunction

endpackage

// File: rtl/ti_and_term.sv
module ti_and_term #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_own,
  input  logic [W-1:0] x_nbr,
  input  logic [W-1:0] y_own,
  input  logic [W-1:0] y_nbr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] prod
);

  always_comb begin
    prod = (x_own & y_own) ^ (x_own & y_nbr) ^ (x_nbr & y_own) ^ mask;
  end

endmodule

// File: rtl/ti_and_mask.sv
module ti_and_mask #(
  parameter int W          = 8,
  parameter bit REFRESH_EN = 1'b1
) (
  input  logic [W-1:0] rnd_a,
  input  logic [W-1:0] rnd_b,
  output logic [W-1:0] m0,
  output logic [W-1:0] m1,
  output logic [W-1:0] m2
);

  generate
    if (REFRESH_EN) begin : g_refresh
      always_comb begin
        m0 = rnd_a;
        m1 = rnd_b;
        m2 = rnd_a ^ rnd_b;
      end
    end else begin : g_plain
      logic [W-1:0] unused_rnd;
      always_comb begin
        unused_rnd = rnd_a ^ rnd_b;
        m0 = '0;
        m1 = '0;
        m2 = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/ti_and_reg.sv
module ti_and_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/ti_and3.sv
module ti_and3 #(
  parameter int W          = 8,
  parameter bit REFRESH_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] a1,
  input  logic [W-1:0] a2,
  input  logic [W-1:0] a3,
  input  logic [W-1:0] b1,
  input  logic [W-1:0] b2,
  input  logic [W-1:0] b3,
  input  logic [W-1:0] r1,
  input  logic [W-1:0] r2,
  output logic         out_valid,
  output logic [W-1:0] z1,
  output logic [W-1:0] z2,
  output logic [W-1:0] z3
);

  import ti_and_pkg::*;

  logic [W-1:0] a_sh [NSHARE];
  logic [W-1:0] b_sh [NSHARE];
  logic [W-1:0] m_sh [NSHARE];
  logic [W-1:0] p_sh [NSHARE];
  logic [W-1:0] z_sh [NSHARE];
  logic         vld_nxt;

  always_comb begin
    a_sh[0] = a1; a_sh[1] = a2; a_sh[2] = a3;
    b_sh[0] = b1; b_sh[1] = b2; b_sh[2] = b3;
  end

  ti_and_mask #(.W(W), .REFRESH_EN(REFRESH_EN)) u_mask (
    .rnd_a (r1),
    .rnd_b (r2),
    .m0    (m_sh[0]),
    .m1    (m_sh[1]),
    .m2    (m_sh[2])
  );

  for (genvar i = 0; i < NSHARE; i++) begin : g_share
    localparam int OWN = own_idx(i);
    localparam int NBR = nbr_idx(i);

    ti_and_term #(.W(W)) u_term (
      .x_own (a_sh[OWN]),
      .x_nbr (a_sh[NBR]),
      .y_own (b_sh[OWN]),
      .y_nbr (b_sh[NBR]),
      .mask  (m_sh[i]),
      .prod  (p_sh[i])
    );

    ti_and_reg #(.W(W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .d     (p_sh[i]),
      .q     (z_sh[i])
    );
  end

  always_comb begin
    vld_nxt = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_nxt;
  end

  assign z1 = z_sh[0];
  assign z2 = z_sh[1];
  assign z3 = z_sh[2];

endmodule

// File: rtl/ti_and3_chk.sv
module ti_and3_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] a1,
  input logic [W-1:0] a2,
  input logic [W-1:0] a3,
  input logic [W-1:0] b1,
  input logic [W-1:0] b2,
  input logic [W-1:0] b3,
  input logic [W-1:0] r1,
  input logic [W-1:0] r2,
  input logic         out_valid,
  input logic [W-1:0] z1,
  input logic [W-1:0] z2,
  input logic [W-1:0] z3
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && z1 == '0 && z2 == '0 && z3 == '0));

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((z1 ^ z2 ^ z3) ==
                  ($past(a1 ^ a2 ^ a3) & $past(b1 ^ b2 ^ b3))));

  // R4
  z1_excl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(in_valid) && a1 == $past(a1) && a2 == $past(a2) &&
     b1 == $past(b1) && b2 == $past(b2) && r1 == $past(r1)) |=> $stable(z1));

  // R5
  z2_excl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(in_valid) && a1 == $past(a1) && a3 == $past(a3) &&
     b1 == $past(b1) && b3 == $past(b3) && r2 == $past(r2)) |=> $stable(z2));

  // R6
  z3_excl1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(in_valid) && a2 == $past(a2) && a3 == $past(a3) &&
     b2 == $past(b2) && b3 == $past(b3) && r1 == $past(r1) &&
     r2 == $past(r2)) |=> $stable(z3));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(z1) && $stable(z2) && $stable(z3)));

endmodule

bind ti_and3 ti_and3_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .a1        (a1),
  .a2        (a2),
  .a3        (a3),
  .b1        (b1),
  .b2        (b2),
  .b3        (b3),
  .r1        (r1),
  .r2        (r2),
  .out_valid (out_valid),
  .z1        (z1),
  .z2        (z2),
  .z3        (z3)
);

// File: tb/ti_and3_tb.sv
`timescale 1ns/1ps
module ti_and3_tb;

  localparam int W = 8;
  localparam int WATCHDOG_CYC = 20000;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] a1, a2, a3, b1, b2, b3, r1, r2;
  logic         out_valid;
  logic [W-1:0] z1, z2, z3;

  int errors;
  int checks;
  bit finished;

  ti_and3 #(.W(W), .REFRESH_EN(1'b1)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a1        (a1),
    .a2        (a2),
    .a3        (a3),
    .b1        (b1),
    .b2        (b2),
    .b3        (b3),
    .r1        (r1),
    .r2        (r2),
    .out_valid (out_valid),
    .z1        (z1),
    .z2        (z2),
    .z3        (z3)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Expected shares from the equations in R4..R7
  function automatic logic [W-1:0] exp_z1(input logic [W-1:0] x1, x2, y1, y2, m1);
    return (x1 & y1) ^ (x1 & y2) ^ (x2 & y1) ^ m1;
  endfunction
  function automatic logic [W-1:0] exp_z2(input logic [W-1:0] x1, x3, y1, y3, m2);
    return (x3 & y3) ^ (x3 & y1) ^ (x1 & y3) ^ m2;
  endfunction
  function automatic logic [W-1:0] exp_z3(input logic [W-1:0] x2, x3, y2, y3, m1, m2);
    return (x2 & y2) ^ (x2 & y3) ^ (x3 & y2) ^ m1 ^ m2;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Split a secret into three random shares
  task automatic split(input logic [W-1:0] s, output logic [W-1:0] s1, s2, s3);
    s1 = W'($urandom);
    s2 = W'($urandom);
    s3 = s ^ s1 ^ s2;
  endtask

  // Drive one operation at negedge, sample after the capturing posedge
  task automatic do_op(input logic [W-1:0] x1, x2, x3, y1, y2, y3, m1, m2,
                       input bit full);
    logic [W-1:0] e1, e2, e3, eu;
    @(negedge clk);
    in_valid = 1'b1;
    a1 = x1; a2 = x2; a3 = x3; b1 = y1; b2 = y2; b3 = y3; r1 = m1; r2 = m2;
    @(negedge clk);
    in_valid = 1'b0;
    e1 = exp_z1(x1, x2, y1, y2, m1);
    e2 = exp_z2(x1, x3, y1, y3, m2);
    e3 = exp_z3(x2, x3, y2, y3, m1, m2);
    eu = (x1 ^ x2 ^ x3) & (y1 ^ y2 ^ y3);
    check(out_valid == 1'b1, "R2 out_valid", W'(out_valid), W'(1));
    check((z1 ^ z2 ^ z3) == eu, "R3 unmasked", z1 ^ z2 ^ z3, eu);
    if (full) begin
      check(z1 == e1, "R4 z1", z1, e1);
      check(z2 == e2, "R5 z2", z2, e2);
      check(z3 == e3, "R6/R7 z3", z3, e3);
    end
  endtask

  initial begin
    #(WATCHDOG_CYC * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] s1, s2, s3, t1, t2, t3, m1, m2, h1, h2, h3;
    errors = 0;
    checks = 0;
    finished = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0;
    a1 = '0; a2 = '0; a3 = '0; b1 = '0; b2 = '0; b3 = '0; r1 = '0; r2 = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, with inputs toggling under reset
    in_valid = 1'b1; a1 = '1; b1 = '1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", W'(out_valid), '0);
    check(z1 == '0 && z2 == '0 && z3 == '0, "R1 shares", z1 | z2 | z3, '0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 idle after reset", W'(out_valid), '0);

    // R3/R7: all four lane combinations, random splits and masks
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 3; k++) begin
        split((c & 2) != 0 ? '1 : '0, s1, s2, s3);
        split((c & 1) != 0 ? '1 : '0, t1, t2, t3);
        do_op(s1, s2, s3, t1, t2, t3, W'($urandom), W'($urandom), 1'b1);
      end
    end

    // R7: zero randomness and all-ones randomness
    split(8'hA5, s1, s2, s3); split(8'h3C, t1, t2, t3);
    do_op(s1, s2, s3, t1, t2, t3, '0, '0, 1'b1);
    do_op(s1, s2, s3, t1, t2, t3, '1, '1, 1'b1);
    do_op(s1, s2, s3, t1, t2, t3, '1, '0, 1'b1);

    // Random operations, back to back through do_op
    for (int n = 0; n < 60; n++) begin
      split(W'($urandom), s1, s2, s3);
      split(W'($urandom), t1, t2, t3);
      do_op(s1, s2, s3, t1, t2, t3, W'($urandom), W'($urandom), 1'b1);
    end

    // R4/R5/R6: flip only the excluded index and check the protected share
    for (int n = 0; n < 8; n++) begin
      split(W'($urandom), s1, s2, s3);
      split(W'($urandom), t1, t2, t3);
      m1 = W'($urandom); m2 = W'($urandom);
      do_op(s1, s2, s3, t1, t2, t3, m1, m2, 1'b0);
      h1 = z1;
      do_op(s1, s2, ~s3, t1, t2, ~t3, m1, m2, 1'b0);
      check(z1 == h1, "R4 index3 excluded", z1, h1);
      h2 = z2;
      do_op(s1, ~s2, ~s3, t1, ~t2, ~t3, m1, m2, 1'b0);
      check(z2 == h2, "R5 index2 excluded", z2, h2);
      do_op(s1, ~s2, s3, t1, ~t2, t3, m1, m2, 1'b0);
      h3 = z3;
      do_op(~s1, ~s2, s3, ~t1, ~t2, t3, m1, m2, 1'b0);
      check(z3 == h3, "R6 index1 excluded", z3, h3);
    end

    // R8: idle cycles with moving inputs leave shares untouched
    split(8'hF0, s1, s2, s3); split(8'h0F, t1, t2, t3);
    do_op(s1, s2, s3, t1, t2, t3, 8'h12, 8'h34, 1'b1);
    h1 = z1; h2 = z2; h3 = z3;
    for (int n = 0; n < 4; n++) begin
      a1 = W'($urandom); a2 = W'($urandom); a3 = W'($urandom);
      b1 = W'($urandom); b2 = W'($urandom); b3 = W'($urandom);
      r1 = W'($urandom); r2 = W'($urandom);
      @(negedge clk);
      check(out_valid == 1'b0, "R2 idle", W'(out_valid), '0);
      check(z1 == h1, "R8 hold z1", z1, h1);
      check(z2 == h2, "R8 hold z2", z2, h2);
      check(z3 == h3, "R8 hold z3", z3, h3);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule